// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of 32 general-purpose pins controlled through a small memory-mapped register port. Software sets output data and output-enable bits to drive pads. It reads back the synchronized pin levels. It also chooses, pin by pin, how an input change is turned into an interrupt event. Events collect in a sticky status register. A single interrupt line leaves the bank. A pin contributes to that line only when its status, interrupt-enable and routing bits are all set.

Each register sits in a 16-byte slot and has four write views:

- a plain write that replaces the whole register;
- a set view that ORs the written ones in;
- a clear view that removes the written ones;
- a toggle view that inverts the written ones.

These views let software change single pins without a read-modify-write race. One use is toggling a pin's polarity while it is in edge mode, which arms it for the opposite edge. Software uses this to emulate detection on both edges.

Pins pass through a two-flop synchronizer before sampling and event detection. The bus is a single-cycle port with no wait states. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_out`, `pin_oe` and `irq_o` are low, and `bus_rdata` is zero.
- R2: A write to byte offset +0x0 of a slot replaces the register. A read from any of the four offsets of a slot returns the register value on `bus_rdata` one cycle after the strobe.
- R3: Offset +0x4 ORs `bus_wdata` into the register, +0x8 clears the bits that are one in `bus_wdata`, and +0xC inverts them. All other bits keep their value.
- R4: Slot 2 (address 0x20) returns the synchronized pin levels, whatever the output-enable bits are. A pin change is visible there from the second rising clock edge after it. Writes to slot 2 have no effect.
- R5: `pin_out` follows the output data register in slot 0 (address 0x00), and `pin_oe` follows the output-enable register in slot 1 (address 0x10).
- R6: The two configuration bits form a trigger code, with the level-select register (slot 5) as the low bit and the polarity register (slot 6) as the high bit. The codes are 0 falling edge, 1 low level, 2 rising edge and 3 high level. In edge mode the matching edge sets the pin's status bit (slot 7) on the third rising clock edge after the pin changes. The bit stays set after the pin returns to its old level.
- R7: In level mode the status bit is set on every cycle in which the active level is present. A clear while the level persists leaves the bit set. Once the level is gone, a clear removes the bit.
- R8: `irq_o` is high when at least one pin has its status, interrupt-enable (slot 4) and routing (slot 3) bits all set. Clearing either the enable bit or the routing bit of the only active pin drops `irq_o`.
- R9: Writing all ones to the status clear view (address 0x78) empties the status register. If a clear and a new event on the same pin fall in the same cycle, the bit ends up set.
- R10: Toggling a pin's polarity bit while it is in edge mode arms it for the opposite edge. After a rising-edge event, a toggle followed by a falling edge sets the status bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address: bits 6:4 slot, bits 3:2 write view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Output enable to pads |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The status register can be written by the bus and set by a pin event in the same cycle. A clear that lands while an event is active must lose.

The bench provokes this by holding a pin at its active level in level mode. It then writes all ones to the status clear view, so the clear and the per-cycle event meet on the same edge. The following read must still show that pin's bit and no other.

Exact event latency is judged on `irq_o`, edge by edge after the pin change. Polarity toggling and gating by the enable and routing bits are judged the same way.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_BITS = $clog2(NUM_SLOTS);
  localparam int VIEW_BITS = 2;
  localparam int ADDR_W    = SLOT_BITS + VIEW_BITS + 2;

  typedef enum logic [VIEW_BITS-1:0] {
    VIEW_WRITE  = 2'd0,
    VIEW_SET    = 2'd1,
    VIEW_CLEAR  = 2'd2,
    VIEW_INVERT = 2'd3
  } view_e;

  typedef enum logic [SLOT_BITS-1:0] {
    SLOT_DOUT  = 3'd0,
    SLOT_OE    = 3'd1,
    SLOT_DIN   = 3'd2,
    SLOT_ROUTE = 3'd3,
    SLOT_IEN   = 3'd4,
    SLOT_LVL   = 3'd5,
    SLOT_POL   = 3'd6,
    SLOT_STAT  = 3'd7
  } slot_e;
endpackage

// File: rtl/gpio_view_reg.sv
module gpio_view_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  view_e        view,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ext_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  // Bus update first, then hardware events OR on top: events win a tie.
  always_comb begin
    q_d = q;
    if (wr_en) begin
      unique case (view)
        VIEW_WRITE:  q_d = wdata;
        VIEW_SET:    q_d = q | wdata;
        VIEW_CLEAR:  q_d = q & ~wdata;
        VIEW_INVERT: q_d = q ^ wdata;
        default:     q_d = q;
      endcase
    end
    q_d  = q_d | ext_set;
    q_en = wr_en | (|ext_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_now,
  output logic [W-1:0] pin_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      pin_now  <= '0;
      pin_prev <= '0;
    end else begin
      meta_q   <= pin_async;
      pin_now  <= meta_q;
      pin_prev <= pin_now;
    end
  end
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
  parameter int W = 32
) (
  input  logic [W-1:0] pin_now,
  input  logic [W-1:0] pin_prev,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] pol_sel,
  output logic [W-1:0] event_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic [1:0] code;
    assign code = {pol_sel[p], lvl_sel[p]};
    always_comb begin
      unique case (code)
        2'd0:    event_o[p] = ~pin_now[p] &  pin_prev[p];
        2'd1:    event_o[p] = ~pin_now[p];
        2'd2:    event_o[p] =  pin_now[p] & ~pin_prev[p];
        default: event_o[p] =  pin_now[p];
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq_o
);
  slot_e           slot;
  view_e           view;
  logic            wr_strobe;
  logic            rd_strobe;
  logic [PINS-1:0] reg_q [NUM_SLOTS];
  logic [PINS-1:0] pin_now, pin_prev, pin_event;
  logic [PINS-1:0] stat_q, ien_q, route_q;
  logic [PINS-1:0] rdata_d;

  assign slot      = slot_e'(bus_addr[ADDR_W-1 -: SLOT_BITS]);
  assign view      = view_e'(bus_addr[VIEW_BITS+1:2]);
  assign wr_strobe = bus_sel &  bus_wr;
  assign rd_strobe = bus_sel & ~bus_wr;

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
    .pin_now(pin_now), .pin_prev(pin_prev)
  );

  gpio_trigger #(.W(PINS)) u_trig (
    .pin_now(pin_now), .pin_prev(pin_prev),
    .lvl_sel(reg_q[SLOT_LVL]), .pol_sel(reg_q[SLOT_POL]),
    .event_o(pin_event)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s == int'(SLOT_DIN)) begin : g_din
      assign reg_q[s] = pin_now;
    end else begin : g_reg
      logic            wr_here;
      logic [PINS-1:0] hw_set;
      assign wr_here = wr_strobe && (slot == slot_e'(s));
      assign hw_set  = (s == int'(SLOT_STAT)) ? pin_event : '0;
      gpio_view_reg #(.W(PINS)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .view(view),
        .wdata(bus_wdata), .ext_set(hw_set), .q(reg_q[s])
      );
    end
  end

  assign stat_q  = reg_q[SLOT_STAT];
  assign ien_q   = reg_q[SLOT_IEN];
  assign route_q = reg_q[SLOT_ROUTE];
  assign pin_out = reg_q[SLOT_DOUT];
  assign pin_oe  = reg_q[SLOT_OE];
  assign irq_o   = |(stat_q & ien_q & route_q);

  always_comb begin
    rdata_d = reg_q[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (rd_strobe) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              irq_o,
  input logic [PINS-1:0]   stat_q
);
  logic wr;
  assign wr = bus_sel && bus_wr;

  a_r2_plain_write_dout: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == {SLOT_DOUT, VIEW_WRITE, 2'b00}) |=> (pin_out == $past(bus_wdata)));

  a_r3_set_view_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == {SLOT_OE, VIEW_SET, 2'b00}) |=> (pin_oe == ($past(pin_oe) | $past(bus_wdata))));

  a_r3_clear_view_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == {SLOT_OE, VIEW_CLEAR, 2'b00}) |=> (pin_oe == ($past(pin_oe) & ~$past(bus_wdata))));

  a_r5_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr[ADDR_W-1 -: SLOT_BITS] == SLOT_DOUT) |=> $stable(pin_out));

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr[ADDR_W-1 -: SLOT_BITS] == SLOT_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_o(irq_o), .stat_q(stat_q)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  function automatic logic [6:0] adr(input int slot, input int view);
    return {slot[2:0], view[1:0], 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input int slot, input int view, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(slot, view); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Driver side of the scoreboard: issue a read, queue the expectation.
  task automatic expect_read(input int slot, input int view, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr(slot, view);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: compare registered read data against queued items.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    check("R1 pin_oe", pin_oe, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    expect_read(7, 0, 32'd0, "R1 status");
    expect_read(6, 0, 32'd0, "R1 polarity");

    // R2 plain write, read through all views
    bus_write(0, 0, 32'hA5A5_0F0F);
    expect_read(0, 0, 32'hA5A5_0F0F, "R2 read +0");
    expect_read(0, 3, 32'hA5A5_0F0F, "R2 read +C");
    check("R5 pin_out", pin_out, 32'hA5A5_0F0F);

    // R3 set / clear / invert views
    bus_write(0, 1, 32'h0000_F000);
    expect_read(0, 1, 32'hA5A5_FF0F, "R3 set view");
    bus_write(0, 2, 32'hA500_0000);
    expect_read(0, 2, 32'h00A5_FF0F, "R3 clear view");
    bus_write(0, 3, 32'hFFFF_0000);
    expect_read(0, 0, 32'hFF5A_FF0F, "R3 invert view");
    bus_write(1, 0, 32'h0000_00FF);
    check("R5 pin_oe", pin_oe, 32'h0000_00FF);
    check("R5 pin_out", pin_out, 32'hFF5A_FF0F);

    // R4 input sampling and ignored writes
    set_pins(32'h1234_5678);
    idle(3);
    expect_read(2, 0, 32'h1234_5678, "R4 din");
    bus_write(2, 0, 32'h0000_0000);
    expect_read(2, 0, 32'h1234_5678, "R4 din write ignored");

    // R6 rising edge on pin 0, exact latency on irq_o
    bus_write(6, 1, 32'h1);
    bus_write(3, 1, 32'h1);
    bus_write(4, 1, 32'h1);
    bus_write(7, 2, 32'hFFFF_FFFF);
    set_pins(32'h1234_5679);
    @(negedge clk); check("R6 irq after 1 edge", {31'd0, irq_o}, 32'd0);
    @(negedge clk); check("R6 irq after 2 edges", {31'd0, irq_o}, 32'd0);
    @(negedge clk); check("R6 irq after 3 edges", {31'd0, irq_o}, 32'd1);
    set_pins(32'h1234_5678);
    idle(3);
    expect_read(7, 0, 32'h1, "R6 status sticky");

    // R8 gating by enable and routing
    bus_write(4, 2, 32'h1);
    check("R8 irq without enable", {31'd0, irq_o}, 32'd0);
    bus_write(4, 1, 32'h1);
    bus_write(3, 2, 32'h1);
    check("R8 irq without routing", {31'd0, irq_o}, 32'd0);
    bus_write(3, 1, 32'h1);
    check("R8 irq all set", {31'd0, irq_o}, 32'd1);

    // R9 clear all
    bus_write(7, 2, 32'hFFFF_FFFF);
    expect_read(7, 0, 32'h0, "R9 clear all");
    check("R9 irq after clear", {31'd0, irq_o}, 32'd0);

    // R10 polarity toggle re-arms for the opposite edge
    set_pins(32'h1234_5679);
    idle(3);
    expect_read(7, 0, 32'h1, "R10 rising event");
    bus_write(7, 2, 32'hFFFF_FFFF);
    bus_write(6, 3, 32'h1);
    set_pins(32'h1234_5678);
    idle(3);
    expect_read(7, 0, 32'h1, "R10 falling event after toggle");
    check("R10 irq", {31'd0, irq_o}, 32'd1);
    bus_write(7, 2, 32'hFFFF_FFFF);

    // R7 / R9 level high on pin 4 (already high): clear collides with event
    bus_write(5, 1, 32'h10);
    bus_write(6, 1, 32'h10);
    idle(2);
    bus_write(7, 2, 32'hFFFF_FFFF);
    expect_read(7, 0, 32'h10, "R7 R9 clear loses to active level");
    set_pins(32'h1234_5668);
    idle(3);
    bus_write(7, 2, 32'hFFFF_FFFF);
    expect_read(7, 0, 32'h0, "R7 clear after level gone");

    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule